// File: doc/BRIEF.md
# Double-Data-Rate Output Serializer

This block turns a stream of word pairs, one pair per system clock cycle, into a single output bus running at twice the rate. On every rising edge of the system clock, both words of the pair are captured together. The first word is then driven on the output for the high half of the clock period. The second word follows during the low half. The first word of a pair always reaches the output before the second.

The second word is copied into a register clocked on the falling edge. The output selection then picks between two values that are already settled, so the bus changes only at clock edges. An enable input decides whether a new pair is taken at a rising edge. While it is low, the pair already held keeps being repeated. Reset is synchronous to the rising edge and clears the output to zero. The data width is a parameter.

Top module: `ddr_out_serializer`

## Requirements
- R1: When `rst` is low and `load_en` is high at a rising edge of `clk`, both `word_a` and `word_b` are captured at that same edge.
- R2: While `clk` is high, `ddr_q` equals the `word_a` value captured at the most recent rising edge.
- R3: While `clk` is low, `ddr_q` equals the `word_b` value captured at the most recent rising edge, so within a cycle `word_a` leads `word_b` in time.
- R4: The low-phase word is held in a falling-edge register that copies the captured `word_b`, and `ddr_q` stays constant across each half period.
- R5: When `rst` is high at a rising edge, both halves of `ddr_q` are zero in the following cycle, whatever the value of `load_en`.
- R6: When `load_en` is low at a rising edge (and `rst` is low), the previously captured pair is repeated unchanged in both halves.
- R7: Changes on `word_a` and `word_b` between rising edges have no effect on `ddr_q` until the next rising edge that captures them.
- R8: The bus width is set by the parameter `DATA_W`, and every bit of both words is carried through, including all-ones and alternating patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; its rising edge is the active edge |
| rst | input | 1 | Synchronous active-high reset, takes priority over the enable |
| load_en | input | 1 | Captures a new pair at the rising edge when high |
| word_a | input | DATA_W | Word driven during the high phase |
| word_b | input | DATA_W | Word driven during the low phase |
| ddr_q | output | DATA_W | Double-data-rate output bus |

## Verification
The assertions assume that `rst`, `load_en` and both data words are settled around each rising edge, and that reset is held high across at least one full cycle, so the falling-edge copy sees a cleared value before it is checked. The stimulus changes every input half a nanosecond after a falling edge. It keeps reset high for several cycles at the start. Data words are altered during the high phase only in the cycles that test R7, well away from the next capture edge.

// File: rtl/ddr_ser_pkg.sv
package ddr_ser_pkg;
  localparam int unsigned DEF_DATA_W = 8;

  typedef enum logic {
    PHASE_LOW  = 1'b0,
    PHASE_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/ddr_pair_reg.sv
module ddr_pair_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [DATA_W-1:0] word_a,
  input  logic [DATA_W-1:0] word_b,
  output logic [DATA_W-1:0] lead_q,
  output logic [DATA_W-1:0] trail_q
);
  // Both words share one rising edge; reset wins over the enable.
  always_ff @(posedge clk) begin
    if (rst) begin
      lead_q  <= '0;
      trail_q <= '0;
    end else if (load_en) begin
      lead_q  <= word_a;
      trail_q <= word_b;
    end
  end
endmodule

// File: rtl/ddr_fall_reg.sv
module ddr_fall_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic [DATA_W-1:0] trail_d,
  output logic [DATA_W-1:0] trail_fq
);
  // Retimes the trailing word to the falling edge so the low phase
  // starts from a settled register output.
  always_ff @(negedge clk) begin
    trail_fq <= trail_d;
  end
endmodule

// File: rtl/ddr_phase_mux.sv
module ddr_phase_mux
  import ddr_ser_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic [DATA_W-1:0] lead_q,
  input  logic [DATA_W-1:0] trail_fq,
  output logic [DATA_W-1:0] ddr_q
);
  phase_e phase;

  always_comb begin
    phase = phase_e'(clk);
    unique case (phase)
      PHASE_HIGH: ddr_q = lead_q;
      default:    ddr_q = trail_fq;
    endcase
  end
endmodule

// File: rtl/ddr_out_serializer.sv
module ddr_out_serializer
  import ddr_ser_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [DATA_W-1:0] word_a,
  input  logic [DATA_W-1:0] word_b,
  output logic [DATA_W-1:0] ddr_q
);
  logic [DATA_W-1:0] lead_q;
  logic [DATA_W-1:0] trail_q;
  logic [DATA_W-1:0] trail_fq;

  ddr_pair_reg #(.DATA_W(DATA_W)) u_pair (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .word_a  (word_a),
    .word_b  (word_b),
    .lead_q  (lead_q),
    .trail_q (trail_q)
  );

  ddr_fall_reg #(.DATA_W(DATA_W)) u_fall (
    .clk      (clk),
    .trail_d  (trail_q),
    .trail_fq (trail_fq)
  );

  ddr_phase_mux #(.DATA_W(DATA_W)) u_mux (
    .clk      (clk),
    .lead_q   (lead_q),
    .trail_fq (trail_fq),
    .ddr_q    (ddr_q)
  );
endmodule

// File: rtl/ddr_out_serializer_chk.sv
module ddr_out_serializer_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              load_en,
  input logic [DATA_W-1:0] word_a,
  input logic [DATA_W-1:0] word_b,
  input logic [DATA_W-1:0] lead_q,
  input logic [DATA_W-1:0] trail_q,
  input logic [DATA_W-1:0] trail_fq
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (lead_q == '0 && trail_q == '0)); // R5

  AST_LOAD_PAIR: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (lead_q == $past(word_a) && trail_q == $past(word_b))); // R1

  AST_HOLD_PAIR: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> ($stable(lead_q) && $stable(trail_q))); // R6

  AST_FALL_COPY: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> trail_fq == trail_q); // R4
endmodule

bind ddr_out_serializer ddr_out_serializer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .load_en  (load_en),
  .word_a   (word_a),
  .word_b   (word_b),
  .lead_q   (lead_q),
  .trail_q  (trail_q),
  .trail_fq (trail_fq)
);

// File: tb/ddr_out_serializer_tb.sv
`timescale 1ns/100ps
module ddr_out_serializer_tb;
  localparam int unsigned W = 12;

  typedef struct {
    logic [W-1:0] hi;
    logic [W-1:0] lo;
    string        req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_en = 1'b0;
  logic [W-1:0] word_a = '0;
  logic [W-1:0] word_b = '0;
  logic [W-1:0] ddr_q;

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;
  exp_t sb_q[$];
  logic [W-1:0] m_hi = '0;
  logic [W-1:0] m_lo = '0;

  ddr_out_serializer #(.DATA_W(W)) u_dut (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .word_a  (word_a),
    .word_b  (word_b),
    .ddr_q   (ddr_q)
  );

  always #2 clk = ~clk;

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: ddr_q=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: sets inputs for the next rising edge and pushes the expected pair.
  task automatic drive(bit r, bit en, logic [W-1:0] a, logic [W-1:0] b,
                       string req, bit disturb = 1'b0);
    exp_t e;
    @(negedge clk);
    #0.5;
    rst = r; load_en = en; word_a = a; word_b = b;
    if (r) begin m_hi = '0; m_lo = '0; end
    else if (en) begin m_hi = a; m_lo = b; end
    e.hi = m_hi; e.lo = m_lo; e.req = req;
    sb_q.push_back(e);
    if (disturb) begin
      @(posedge clk);
      #1;
      word_a = ~a;
      word_b = ~b;
    end
  endtask

  // Monitor: two samples in each half period.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #0.5;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        chk({e.req, "/high"}, ddr_q, e.hi);
        #1;
        chk({e.req, "/R4 high steady"}, ddr_q, e.hi);
        @(negedge clk);
        #0.5;
        chk({e.req, "/low"}, ddr_q, e.lo);
        #1;
        chk({e.req, "/R4 low steady"}, ddr_q, e.lo);
      end
    end
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) drive(1'b1, 1'b0, 12'h5a5, 12'h3c3, "R5 reset");
    drive(1'b0, 1'b1, 12'h123, 12'h456, "R1 R2 R3 load");
    drive(1'b0, 1'b1, 12'h789, 12'habc, "R1 R2 R3 load");
    drive(1'b0, 1'b1, 12'h000, 12'hfff, "R2 R3 order");
    for (int i = 0; i < 8; i++)
      drive(1'b0, 1'b1, W'(i * 397 + 11), W'(i * 1201 + 7), "R1 R2 R3 sweep");
    drive(1'b0, 1'b0, 12'hdea, 12'hbee, "R6 hold");
    drive(1'b0, 1'b0, 12'h111, 12'h222, "R6 hold");
    drive(1'b0, 1'b1, 12'h0f0, 12'h30c, "R7 disturb", 1'b1);
    drive(1'b0, 1'b1, 12'h246, 12'h8ac, "R7 after disturb", 1'b1);
    drive(1'b0, 1'b0, 12'h999, 12'h777, "R6 R7 hold disturbed", 1'b1);
    drive(1'b1, 1'b1, 12'hfed, 12'hcba, "R5 reset over enable");
    drive(1'b0, 1'b0, 12'hfed, 12'hcba, "R5 R6 hold after reset");
    drive(1'b0, 1'b1, 12'hfff, 12'hfff, "R8 all ones");
    drive(1'b0, 1'b1, 12'haaa, 12'h555, "R8 alternating");
    drive(1'b0, 1'b1, 12'h800, 12'h001, "R8 edge bits");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule